// File: doc/BRIEF.md
# Pointer-Window GPIO Controller

This block is a general-purpose I/O controller for a parameterised number of pins (up to 16). It has no directly mapped registers. The host reaches all of its state through one 16-bit window word. In that word, bits [14:8] name an 8-bit internal register and bits [7:0] carry the byte that goes to it or comes from it. Bit 15 is the update flag:

- A write with the flag clear only moves the internal pointer. A later read then fetches the byte that the pointer selects.
- A write with the flag set also stores the low byte into the selected register.

The internal space holds:

- **Direction bytes** at 0x62 and 0x63, where 1 means input.
- **Output latch bytes** at 0x64 and 0x65.
- **Function selectors** at 0x68 to 0x6F, one 3-bit code per pin with two pins per byte. The codes are 0 for plain GPIO, 1 for trigger output and 2 for event-request input. The block only exports these codes to neighbouring logic.
- **Two general configuration bytes** at 0x60 and 0x61.
- **A miscellaneous byte** at 0x02, whose bit 7 selects normal management-interface mode.

Reads of a data byte are mixed per pin. An input pin returns its sampled level and an output pin returns its latch.

Top module: `gpio_window_bank`

## Requirements
- R1: Every host write loads window bits [14:8] into the pointer. One cycle after a read strobe, host_rdata holds {0, pointer, selected byte}, so the update flag always reads back as 0.
- R2: A write with bit 15 clear changes no stored byte, no pin output, no output enable, no function code and no mode output.
- R3: A write with bit 15 set stores bits [7:0] into the register named by bits [14:8]. The new value is visible on the outputs one clock later.
- R4: Pin p's direction is bit p mod 8 of byte 0x62 (pins 0 to 7) or byte 0x63 (pins 8 to 15). Value 1 makes the pin an input, and pin_oe[p] is the inverse of that bit.
- R5: Pin p's output latch is bit p mod 8 of byte 0x64 or 0x65, and it drives pin_out[p] whatever the direction.
- R6: Reading 0x64 or 0x65 returns, per pin, the registered sample of pin_in when the pin is an input and the latch when it is an output.
- R7: The function code of pin p sits in byte 0x68 + p/2, in bits [2:0] for even p and bits [6:4] for odd p. Bits 3 and 7 read as 0. The code is exported on func_sel[3p+2:3p].
- R8: Bytes 0x60, 0x61 and 0x02 store and read back all 8 bits. Bit 7 of 0x02 drives mgmt_normal.
- R9: Bits that belong to pins at or above NPINS read as 0, and writes to them are ignored.
- R10: After reset all pins are inputs with function 0, and every latch and configuration byte is 0. Addresses outside the map read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Window write strobe |
| host_wdata | input | 16 | Window write word: update flag, pointer, data byte |
| host_rd | input | 1 | Window read strobe |
| host_rdata | output | 16 | Registered window read word |
| pin_in | input | NPINS | Pin input levels |
| pin_out | output | NPINS | Pin output latch values |
| pin_oe | output | NPINS | Pin output enables (1 = drive) |
| func_sel | output | 3*NPINS | Per-pin function codes |
| mgmt_normal | output | 1 | Normal management-interface mode select |

## Verification
A wrong pointer shows up on the very next read, because host_rdata echoes the pointer next to the byte. A wrong direction or latch bit appears on pin_oe or pin_out one clock after the update write. A corrupted function field is exposed at once on func_sel and again in the read byte, and a mis-decoded address or pin mask shows up as a nonzero read of a byte that should be empty. The mixed data readback is checked under two different pin_in patterns. This makes a swapped input/latch selection visible within two cycles of the pin change.

// File: rtl/gpio_win_pkg.sv
package gpio_win_pkg;
  localparam int PTR_W    = 7;
  localparam int BYTE_W   = 8;
  localparam int FN_W     = 3;
  localparam int MAX_PINS = 16;

  localparam logic [PTR_W-1:0] A_MISC = 7'h02;
  localparam logic [PTR_W-1:0] A_CFG0 = 7'h60;
  localparam logic [PTR_W-1:0] A_CFG1 = 7'h61;
  localparam logic [PTR_W-1:0] A_DIR0 = 7'h62;
  localparam logic [PTR_W-1:0] A_DIR1 = 7'h63;
  localparam logic [PTR_W-1:0] A_DAT0 = 7'h64;
  localparam logic [PTR_W-1:0] A_DAT1 = 7'h65;
  localparam logic [PTR_W-1:0] A_FN0  = 7'h68;

  typedef struct packed {
    logic               upd;
    logic [PTR_W-1:0]   ptr;
    logic [BYTE_W-1:0]  dat;
  } win_word_t;
endpackage

// File: rtl/gpio_win_decode.sv
module gpio_win_decode
  import gpio_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  win_word_t         host_word,
  output logic [PTR_W-1:0]  ptr_q,
  output logic              wr_stb,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_byte
);
  // pointer follows every write; the update flag is never stored
  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (host_wr) ptr_q <= host_word.ptr;
  end

  always_comb begin
    wr_stb  = host_wr & host_word.upd;
    wr_addr = host_word.ptr;
    wr_byte = host_word.dat;
  end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
  import gpio_win_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  lat_q,
  output logic [NPINS-1:0]  samp_q,
  output logic [NPINS*FN_W-1:0] fn_q
);
  always_ff @(posedge clk) begin
    if (rst) samp_q <= '0;
    else     samp_q <= pin_in;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam logic [PTR_W-1:0] DIR_A = PTR_W'(A_DIR0 + p / 8);
    localparam logic [PTR_W-1:0] DAT_A = PTR_W'(A_DAT0 + p / 8);
    localparam logic [PTR_W-1:0] FN_A  = PTR_W'(A_FN0 + p / 2);
    localparam int BIT    = p % 8;
    localparam int FN_LSB = (p % 2) * 4;

    always_ff @(posedge clk) begin
      if (rst) begin
        dir_q[p]            <= 1'b1;
        lat_q[p]            <= 1'b0;
        fn_q[p*FN_W +: FN_W] <= '0;
      end else if (wr_stb) begin
        if (wr_addr == DIR_A) dir_q[p] <= wr_byte[BIT];
        if (wr_addr == DAT_A) lat_q[p] <= wr_byte[BIT];
        if (wr_addr == FN_A)  fn_q[p*FN_W +: FN_W] <= wr_byte[FN_LSB +: FN_W];
      end
    end

    // R7
    fn_store_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && wr_addr == FN_A) |=> fn_q[p*FN_W +: FN_W] == $past(wr_byte[FN_LSB +: FN_W]));
  end
endmodule

// File: rtl/gpio_win_readback.sv
module gpio_win_readback
  import gpio_win_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_rd,
  input  logic [PTR_W-1:0]  ptr_q,
  input  logic [NPINS-1:0]  dir_q,
  input  logic [NPINS-1:0]  lat_q,
  input  logic [NPINS-1:0]  samp_q,
  input  logic [NPINS*FN_W-1:0] fn_q,
  input  logic [BYTE_W-1:0] cfg0_q,
  input  logic [BYTE_W-1:0] cfg1_q,
  input  logic [BYTE_W-1:0] misc_q,
  output logic [15:0]       host_rdata
);
  localparam int FN_ALL = MAX_PINS * FN_W;

  logic [MAX_PINS-1:0] dir16, view16;
  logic [FN_ALL-1:0]   fn48;
  logic [BYTE_W-1:0]   sel_byte;
  int                  fbase;

  always_comb begin
    dir16  = MAX_PINS'(dir_q);
    view16 = MAX_PINS'((dir_q & samp_q) | (~dir_q & lat_q));
    fn48   = FN_ALL'(fn_q);
    fbase  = int'(ptr_q[2:0]) * 2 * FN_W;
    case (ptr_q)
      A_MISC:  sel_byte = misc_q;
      A_CFG0:  sel_byte = cfg0_q;
      A_CFG1:  sel_byte = cfg1_q;
      A_DIR0:  sel_byte = dir16[7:0];
      A_DIR1:  sel_byte = dir16[15:8];
      A_DAT0:  sel_byte = view16[7:0];
      A_DAT1:  sel_byte = view16[15:8];
      default: begin
        if (ptr_q[6:3] == A_FN0[6:3])
          sel_byte = {1'b0, fn48[fbase + FN_W +: FN_W], 1'b0, fn48[fbase +: FN_W]};
        else
          sel_byte = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= {1'b0, ptr_q, sel_byte};
  end
endmodule

// File: rtl/gpio_window_bank.sv
module gpio_window_bank
  import gpio_win_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_wr,
  input  logic [15:0]           host_wdata,
  input  logic                  host_rd,
  output logic [15:0]           host_rdata,
  input  logic [NPINS-1:0]      pin_in,
  output logic [NPINS-1:0]      pin_out,
  output logic [NPINS-1:0]      pin_oe,
  output logic [NPINS*3-1:0]    func_sel,
  output logic                  mgmt_normal
);
  localparam logic [15:0] PMASK = 16'((32'd1 << NPINS) - 1);

  logic [PTR_W-1:0]  ptr_q, wr_addr;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_byte;
  logic [NPINS-1:0]  dir_q, lat_q, samp_q;
  logic [NPINS*FN_W-1:0] fn_q;
  logic [BYTE_W-1:0] cfg0_q, cfg1_q, misc_q;

  gpio_win_decode u_dec (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_word(host_wdata),
    .ptr_q(ptr_q), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_byte(wr_byte)
  );

  gpio_pin_bank #(.NPINS(NPINS)) u_pins (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .pin_in(pin_in), .dir_q(dir_q), .lat_q(lat_q), .samp_q(samp_q), .fn_q(fn_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
      misc_q <= '0;
    end else if (wr_stb) begin
      if (wr_addr == A_CFG0) cfg0_q <= wr_byte;
      if (wr_addr == A_CFG1) cfg1_q <= wr_byte;
      if (wr_addr == A_MISC) misc_q <= wr_byte;
    end
  end

  gpio_win_readback #(.NPINS(NPINS)) u_rd (
    .clk(clk), .rst(rst), .host_rd(host_rd), .ptr_q(ptr_q),
    .dir_q(dir_q), .lat_q(lat_q), .samp_q(samp_q), .fn_q(fn_q),
    .cfg0_q(cfg0_q), .cfg1_q(cfg1_q), .misc_q(misc_q), .host_rdata(host_rdata)
  );

  assign pin_out     = lat_q;
  assign pin_oe      = ~dir_q;
  assign func_sel    = fn_q;
  assign mgmt_normal = misc_q[7];

  logic [15:0] oe16, out16;
  assign oe16  = 16'(pin_oe);
  assign out16 = 16'(pin_out);

  // R1
  rd_word_chk: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> (host_rdata[15] == 1'b0) && (host_rdata[14:8] == $past(ptr_q)));

  // R2
  ptr_only_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !host_wdata[15]) |=>
      $stable(pin_out) && $stable(pin_oe) && $stable(func_sel) && $stable(mgmt_normal));

  // R4
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_wdata[15] && host_wdata[14:8] == A_DIR0) |=>
      oe16[7:0] == (~$past(host_wdata[7:0]) & PMASK[7:0]));

  // R5
  latch_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_wdata[15] && host_wdata[14:8] == A_DAT0) |=>
      out16[7:0] == ($past(host_wdata[7:0]) & PMASK[7:0]));

  // R8
  misc_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_wdata[15] && host_wdata[14:8] == A_MISC) |=>
      mgmt_normal == $past(host_wdata[7]));
endmodule

// File: tb/gpio_window_bank_bench.sv
module gpio_window_bank_bench;
  localparam int NP = 12;

  logic          clk = 0;
  logic          rst = 1;
  logic          host_wr = 0, host_rd = 0;
  logic [15:0]   host_wdata = '0;
  logic [15:0]   host_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic [NP*3-1:0] func_sel;
  logic          mgmt_normal;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  always #4 clk = ~clk;

  gpio_window_bank #(.NPINS(NP)) u_gpio_window_bank (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .func_sel(func_sel), .mgmt_normal(mgmt_normal)
  );

  task automatic check_val(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected word per completed read
  always @(posedge clk) rd_seen <= host_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1 actual=%h expected=none", host_rdata);
      end else begin
        check_val(64'(host_rdata), 64'(exp_q.pop_front()), tag_q.pop_front());
      end
    end
  end

  task automatic win_write(input logic upd, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_wdata = {upd, a, d};
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic expect_read(input logic [6:0] a, input logic [7:0] d, input string req);
    win_write(1'b0, a, 8'hEE);
    exp_q.push_back({1'b0, a, d});
    tag_q.push_back(req);
    @(negedge clk);
    host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  logic [NP*3-1:0] exp_fn;

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    // R10 reset state
    check_val(64'(pin_oe), 64'h0, "R10 oe after reset");
    check_val(64'(pin_out), 64'h0, "R10 out after reset");
    check_val(64'(func_sel), 64'h0, "R10 func after reset");
    check_val(64'(mgmt_normal), 64'h0, "R10 mode after reset");
    check_val(64'(host_rdata), 64'h0, "R10 rdata after reset");
    expect_read(7'h62, 8'hFF, "R10 dir0 reset");
    expect_read(7'h63, 8'h0F, "R9 dir1 unimplemented bits");
    expect_read(7'h10, 8'h00, "R10 unmapped read");

    // R4 direction, R5 latch, R6 mixed readback
    win_write(1'b1, 7'h62, 8'hF0);
    check_val(64'(pin_oe), 64'h00F, "R4 oe pins0-3");
    win_write(1'b1, 7'h64, 8'hA5);
    check_val(64'(pin_out), 64'h0A5, "R5 latch low byte");
    pin_in = 12'h3C0;
    idle(2);
    expect_read(7'h64, 8'hC5, "R6 mixed data read");
    pin_in = 12'h030;
    idle(2);
    expect_read(7'h64, 8'h35, "R6 second pin pattern");

    // R9 upper byte with partial pins
    win_write(1'b1, 7'h63, 8'h00);
    check_val(64'(pin_oe), 64'hF0F, "R4 oe pins8-11");
    expect_read(7'h63, 8'h00, "R4 dir1 read");
    win_write(1'b1, 7'h65, 8'hFF);
    check_val(64'(pin_out), 64'hFA5, "R9 latch high ignores pins12-15");
    expect_read(7'h65, 8'h0F, "R9 data1 read masked");
    win_write(1'b1, 7'h63, 8'hFF);
    expect_read(7'h63, 8'h0F, "R9 dir1 write masked");
    check_val(64'(pin_oe), 64'h00F, "R4 oe pins8-11 back to input");

    // R7 function selectors
    win_write(1'b1, 7'h68, 8'h21);
    win_write(1'b1, 7'h6D, 8'h12);
    exp_fn = '0;
    exp_fn[2:0] = 3'd1; exp_fn[5:3] = 3'd2;
    exp_fn[32:30] = 3'd2; exp_fn[35:33] = 3'd1;
    check_val(64'(func_sel), 64'(exp_fn), "R7 func fields");
    expect_read(7'h68, 8'h21, "R7 func byte read");
    win_write(1'b1, 7'h68, 8'hFF);
    expect_read(7'h68, 8'h77, "R7 reserved bits zero");
    exp_fn[5:0] = 6'h3F;
    check_val(64'(func_sel), 64'(exp_fn), "R7 func all ones");
    win_write(1'b1, 7'h6E, 8'h33);
    expect_read(7'h6E, 8'h00, "R9 func unimplemented pins");

    // R2 pointer-only write, R3 update write
    win_write(1'b0, 7'h64, 8'h3C);
    check_val(64'(pin_out), 64'hFA5, "R2 pointer write keeps latch");
    check_val(64'(func_sel), 64'(exp_fn), "R2 pointer write keeps func");
    win_write(1'b1, 7'h60, 8'h5A);
    expect_read(7'h60, 8'h5A, "R8 cfg0 read");
    win_write(1'b1, 7'h61, 8'hC3);
    expect_read(7'h61, 8'hC3, "R8 cfg1 read");
    win_write(1'b1, 7'h02, 8'h81);
    check_val(64'(mgmt_normal), 64'h1, "R8 mode bit");
    expect_read(7'h02, 8'h81, "R3 misc stored");
    win_write(1'b0, 7'h02, 8'h00);
    check_val(64'(mgmt_normal), 64'h1, "R2 pointer write keeps mode");

    // R10 unmapped writes
    win_write(1'b1, 7'h10, 8'h55);
    expect_read(7'h10, 8'h00, "R10 unmapped write ignored");
    win_write(1'b1, 7'h66, 8'h11);
    expect_read(7'h66, 8'h00, "R10 gap address ignored");

    // R1 pointer echo after a plain read without a new write
    exp_q.push_back({1'b0, 7'h66, 8'h00});
    tag_q.push_back("R1 repeated read");
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
    @(negedge clk);

    // R10 reset again
    rst = 1;
    idle(2);
    rst = 0;
    idle(1);
    check_val(64'(pin_oe), 64'h0, "R10 oe after second reset");
    check_val(64'(pin_out), 64'h0, "R10 out after second reset");
    check_val(64'(func_sel), 64'h0, "R10 func after second reset");
    check_val(64'(mgmt_normal), 64'h0, "R10 mode after second reset");
    expect_read(7'h60, 8'h00, "R10 cfg0 after reset");
    expect_read(7'h62, 8'hFF, "R10 dir0 after second reset");

    idle(2);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 actual=%0d pending expected=0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule